// File: doc/BRIEF.md
# Two-Stage Image Line Resizer

This block rescales one line of 8-bit pixels to a new length. Scaling happens in two steps. The first step is a coarse decimation that halves the line up to twice, averaging neighbouring pairs. The second step is a fine linear interpolation. It walks a fixed-point phase across the reduced line and blends each pair of neighbours. Wider pixels, the vertical axis and multi-component formats are handled by instantiating the block once per component or axis.

A configuration strobe supplies the input and output lengths. From these the block derives two values on its own: the number of halvings and a 14-bit step with 13 fractional bits. The step comes from a short sequential divider. Length pairs that the block cannot handle are flagged as errors. After a successful configuration, the block alternates between two phases. First it accepts one full input line on a valid/ready stream, where the first pixel is marked with a start-of-line flag. Then it emits the resized line on a second valid/ready stream, again with a start-of-line flag on the first pixel. A new configuration is taken only while the block is idle or waiting for input, never while it is dividing or emitting.

Top module: `line_resizer`

## Requirements
- R1: A configuration is rejected, with `cfgErr` set, the coefficient word cleared and `inReady` held low, when the input length is above 4096 or below 1, or when the output length is above 1024 or below 2.
- R2: A configuration whose output length times 4 is less than the input length is rejected in the same way. A ratio of exactly 4:1 is accepted.
- R3: The halving count in `coefWord[15:14]` is found by starting from the input length and halving the working length, at most twice, as long as it is above 1024 or at least twice the output length.
- R4: The step in `coefWord[13:0]` equals floor(8192 × (working length − 1) / (output length − 1)).
- R5: A step of 16384 or more is replaced by 0x3FFF, and `cfgOvf` is set.
- R6: `cfgBusy` stays high for no more than 16 cycles after a configuration is taken.
- R7: Each active halving stage outputs (a + b + 1) >> 1 for each consecutive pixel pair of its line. An unpaired last pixel is dropped, so the working length is the input length shifted right by the halving count.
- R8: Output pixel j uses phase p = j × step. Let i = p >> 13 and f = bits 12:5 of p. The output is (L × (256 − f) + R × f + 128) >> 8, where L is working pixel i and R is working pixel i+1. Both indices are clamped to the last working pixel.
- R9: Each input line yields exactly the configured number of output pixels, and `outSol` is high only on the first of them.
- R10: Pixels offered before a start-of-line marker are consumed and discarded, and `inReady` is low while output pixels are pending.
- R11: While `outValid` is high and `outReady` is low, `outData` and `outSol` hold their values.
- R12: After reset, `inReady`, `outValid`, `cfgBusy`, `cfgErr` and `cfgOvf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgStart | input | 1 | Configuration request strobe |
| cfgInSize | input | 13 | Input line length in pixels |
| cfgOutSize | input | 11 | Output line length in pixels |
| cfgBusy | output | 1 | Step calculation in progress |
| cfgErr | output | 1 | Last configuration was rejected |
| cfgOvf | output | 1 | Step was clamped to its maximum |
| coefWord | output | 16 | Halving count (15:14) and step (13:0) |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Input pixel accepted when valid |
| inSol | input | 1 | Input pixel is first of a line |
| inData | input | 8 | Input pixel |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Downstream accepts output pixel |
| outSol | output | 1 | Output pixel is first of a line |
| outData | output | 8 | Output pixel |

## Verification
The coefficient word and flags become valid at a fixed point: 16 cycles after the edge that takes the configuration, which is when `cfgBusy` falls. A rejected configuration shows `cfgErr` one cycle after that edge. The first output pixel is valid in the cycle right after the last input pixel is accepted, and each accepted output moves the phase on by one step at the next edge. For these reasons the checks never use fixed delays. They sample at falling edges and poll `cfgBusy`, `inReady` and `outValid`, and they compare each accepted output against a model built from the requirement formulas. Stalled outputs are compared with the value seen on the previous stalled cycle.

// File: rtl/resz_pkg.sv
package resz_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_LOAD, ST_EMIT} rszState_e;

  typedef struct packed {
    logic lineStart;
    logic pixAccept;
    logic emitAdv;
  } rszStrobe_t;
endpackage

// File: rtl/resz_div.sv
module resz_div #(
  parameter int DIVD_W = 23,
  parameter int DVS_W  = 10,
  parameter int Q_W    = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   quo
);
  localparam int TOP_W = DIVD_W - Q_W;
  localparam int CNT_W = $clog2(Q_W + 1);

  logic [DVS_W-1:0] rem;
  logic [DVS_W-1:0] dvs;
  logic [Q_W-1:0]   sh;
  logic [CNT_W-1:0] cnt;
  logic [DVS_W:0]   trial;
  logic [DVS_W:0]   diff;
  logic             fit;

  always_comb begin
    trial = {rem, sh[Q_W-1]};
    diff  = trial - {1'b0, dvs};
    fit   = trial >= {1'b0, dvs};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem  <= '0;
      dvs  <= '0;
      sh   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= {{(DVS_W-TOP_W){1'b0}}, dividend[DIVD_W-1:Q_W]};
        sh   <= dividend[Q_W-1:0];
        dvs  <= divisor;
        cnt  <= CNT_W'(Q_W);
        busy <= 1'b1;
      end else if (busy) begin
        rem <= fit ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
        sh  <= {sh[Q_W-2:0], fit};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = sh;
endmodule

// File: rtl/resz_ctrl.sv
module resz_ctrl
  import resz_pkg::*;
#(
  parameter int IN_MAX  = 4096,
  parameter int OUT_MAX = 1024,
  parameter int DEC_MAX = 2,
  parameter int FRAC_W  = 13,
  parameter int STEP_W  = 14,
  localparam int IN_W   = $clog2(IN_MAX) + 1,
  localparam int OUT_W  = $clog2(OUT_MAX) + 1,
  localparam int ADDR_W = $clog2(OUT_MAX),
  localparam int DEC_W  = $clog2(DEC_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgStart,
  input  logic [IN_W-1:0]   cfgInSize,
  input  logic [OUT_W-1:0]  cfgOutSize,
  input  logic              inValid,
  input  logic              inSol,
  input  logic              outReady,
  output logic              inReady,
  output logic              outValid,
  output logic              outSol,
  output logic              cfgBusy,
  output logic              cfgErr,
  output logic              cfgOvf,
  output logic [DEC_W-1:0]  decim,
  output logic [STEP_W-1:0] step,
  output logic [ADDR_W:0]   wSize,
  output rszStrobe_t        strb
);
  localparam int Q_W    = STEP_W + 1;
  localparam int DIVD_W = ADDR_W + FRAC_W;

  rszState_e        state;
  logic [IN_W-1:0]  inSizeR;
  logic [OUT_W-1:0] outSizeR;
  logic [IN_W-1:0]  inCnt;
  logic [OUT_W-1:0] emitCnt;
  logic             lineOpen;

  logic [IN_W:0]    wTry;
  logic [DEC_W-1:0] nTry;
  logic [IN_W:0]    twiceOut;
  logic [IN_W:0]    quadOut;
  logic [IN_W:0]    wMinus1;
  logic [OUT_W-1:0] outMinus1;
  logic             cfgBad;
  logic             cfgTake;
  logic             divStart;
  logic [DIVD_W-1:0] dividend;
  logic             divBusy;
  logic             divDone;
  logic [Q_W-1:0]   quo;
  logic             accept;
  logic [IN_W-1:0]  cntNext;

  always_comb begin
    twiceOut = (IN_W+1)'({cfgOutSize, 1'b0});
    quadOut  = (IN_W+1)'({cfgOutSize, 2'b00});
    wTry     = (IN_W+1)'(cfgInSize);
    nTry     = '0;
    for (int k = 0; k < DEC_MAX; k++) begin
      if (wTry > (IN_W+1)'(OUT_MAX) || wTry >= twiceOut) begin
        wTry = wTry >> 1;
        nTry = nTry + 1'b1;
      end
    end
    cfgBad = (cfgInSize > IN_W'(IN_MAX)) || (cfgInSize == '0) ||
             (cfgOutSize > OUT_W'(OUT_MAX)) || (cfgOutSize < OUT_W'(2)) ||
             (quadOut < (IN_W+1)'(cfgInSize));
    wMinus1   = wTry - 1'b1;
    outMinus1 = cfgOutSize - 1'b1;
    dividend  = {wMinus1[ADDR_W-1:0], {FRAC_W{1'b0}}};
    cfgTake   = cfgStart && (state == ST_IDLE || state == ST_LOAD);
    divStart  = cfgTake && !cfgBad;
  end

  resz_div #(.DIVD_W(DIVD_W), .DVS_W(ADDR_W), .Q_W(Q_W)) i_div (
    .clk      (clk),
    .rstN     (rstN),
    .start    (divStart),
    .dividend (dividend),
    .divisor  (outMinus1[ADDR_W-1:0]),
    .busy     (divBusy),
    .done     (divDone),
    .quo      (quo)
  );

  assign inReady  = (state == ST_LOAD);
  assign outValid = (state == ST_EMIT);
  assign outSol   = outValid && (emitCnt == '0);
  assign cfgBusy  = (state == ST_CALC);

  always_comb begin
    accept         = inValid && inReady;
    strb.lineStart = accept && inSol;
    strb.pixAccept = accept && (inSol || lineOpen);
    strb.emitAdv   = outValid && outReady;
    cntNext        = inSol ? IN_W'(1) : inCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      inSizeR  <= '0;
      outSizeR <= '0;
      inCnt    <= '0;
      emitCnt  <= '0;
      lineOpen <= 1'b0;
      cfgErr   <= 1'b0;
      cfgOvf   <= 1'b0;
      decim    <= '0;
      step     <= '0;
      wSize    <= '0;
    end else if (cfgTake) begin
      cfgErr   <= cfgBad;
      cfgOvf   <= 1'b0;
      lineOpen <= 1'b0;
      if (cfgBad) begin
        state <= ST_IDLE;
        decim <= '0;
        step  <= '0;
      end else begin
        state    <= ST_CALC;
        decim    <= nTry;
        wSize    <= wTry[ADDR_W:0];
        inSizeR  <= cfgInSize;
        outSizeR <= cfgOutSize;
      end
    end else begin
      unique case (state)
        ST_CALC: if (divDone) begin
          state  <= ST_LOAD;
          step   <= quo[Q_W-1] ? {STEP_W{1'b1}} : quo[STEP_W-1:0];
          cfgOvf <= quo[Q_W-1];
        end
        ST_LOAD: if (strb.pixAccept) begin
          inCnt    <= cntNext;
          lineOpen <= 1'b1;
          if (cntNext == inSizeR) begin
            state    <= ST_EMIT;
            lineOpen <= 1'b0;
            emitCnt  <= '0;
          end
        end
        ST_EMIT: if (strb.emitAdv) begin
          emitCnt <= emitCnt + 1'b1;
          if (emitCnt == outSizeR - 1'b1) state <= ST_LOAD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/resz_dp.sv
module resz_dp
  import resz_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int OUT_MAX = 1024,
  parameter int DEC_MAX = 2,
  parameter int FRAC_W  = 13,
  parameter int STEP_W  = 14,
  localparam int ADDR_W = $clog2(OUT_MAX),
  localparam int DEC_W  = $clog2(DEC_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rszStrobe_t        strb,
  input  logic [PIX_W-1:0]  inData,
  input  logic [DEC_W-1:0]  decim,
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W:0]   wSize,
  output logic [PIX_W-1:0]  outData
);
  localparam int IDX_W = ADDR_W + 1;
  localparam int ACC_W = IDX_W + FRAC_W;
  localparam int WT_W  = 8;
  localparam int BL_W  = PIX_W + WT_W + 2;

  logic             sv [DEC_MAX+1];
  logic [PIX_W-1:0] sd [DEC_MAX+1];

  assign sv[0] = strb.pixAccept;
  assign sd[0] = inData;

  for (genvar k = 0; k < DEC_MAX; k++) begin : g_half
    logic             ph;
    logic             phEff;
    logic             on;
    logic [PIX_W-1:0] hold;
    logic [PIX_W:0]   sum;

    assign on    = (DEC_W'(k) < decim);
    assign phEff = ph && !strb.lineStart;
    assign sum   = {1'b0, hold} + {1'b0, sd[k]} + 1'b1;
    assign sv[k+1] = on ? (sv[k] && phEff) : sv[k];
    assign sd[k+1] = on ? sum[PIX_W:1] : sd[k];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ph   <= 1'b0;
        hold <= '0;
      end else if (sv[k]) begin
        ph <= !phEff;
        if (!phEff) hold <= sd[k];
      end else if (strb.lineStart) begin
        ph <= 1'b0;
      end
    end
  end

  logic [PIX_W-1:0] mem [OUT_MAX];
  logic [IDX_W-1:0] wAddr;
  logic [IDX_W-1:0] wAddrEff;
  logic             wrEn;

  assign wAddrEff = strb.lineStart ? '0 : wAddr;
  assign wrEn     = sv[DEC_MAX] && (wAddrEff < IDX_W'(OUT_MAX));

  always_ff @(posedge clk) begin
    if (wrEn) mem[wAddrEff[ADDR_W-1:0]] <= sd[DEC_MAX];
  end

  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wAddr <= '0;
      acc   <= '0;
    end else begin
      if (sv[DEC_MAX]) wAddr <= wAddrEff + 1'b1;
      else if (strb.lineStart) wAddr <= '0;
      if (strb.lineStart) acc <= '0;
      else if (strb.emitAdv) acc <= acc + ACC_W'(step);
    end
  end

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idxNext;
  logic [IDX_W-1:0] wLast;
  logic [IDX_W-1:0] leftIdx;
  logic [IDX_W-1:0] rightIdx;
  logic [WT_W-1:0]  frac;
  logic [PIX_W-1:0] leftPix;
  logic [PIX_W-1:0] rightPix;
  logic [BL_W-1:0]  blend;

  always_comb begin
    idx      = acc[ACC_W-1:FRAC_W];
    idxNext  = idx + 1'b1;
    wLast    = wSize - 1'b1;
    leftIdx  = (idx > wLast) ? wLast : idx;
    rightIdx = (idxNext > wLast) ? wLast : idxNext;
    frac     = acc[FRAC_W-1 -: WT_W];
    leftPix  = mem[leftIdx[ADDR_W-1:0]];
    rightPix = mem[rightIdx[ADDR_W-1:0]];
    blend    = BL_W'(leftPix) * (BL_W'(1 << WT_W) - BL_W'(frac))
             + BL_W'(rightPix) * BL_W'(frac)
             + BL_W'(1 << (WT_W - 1));
    outData  = blend[WT_W +: PIX_W];
  end
endmodule

// File: rtl/line_resizer.sv
module line_resizer
  import resz_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int IN_MAX  = 4096,
  parameter int OUT_MAX = 1024,
  parameter int DEC_MAX = 2,
  parameter int FRAC_W  = 13,
  parameter int STEP_W  = 14,
  localparam int IN_W   = $clog2(IN_MAX) + 1,
  localparam int OUT_W  = $clog2(OUT_MAX) + 1,
  localparam int ADDR_W = $clog2(OUT_MAX),
  localparam int DEC_W  = $clog2(DEC_MAX + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgStart,
  input  logic [IN_W-1:0]         cfgInSize,
  input  logic [OUT_W-1:0]        cfgOutSize,
  output logic                    cfgBusy,
  output logic                    cfgErr,
  output logic                    cfgOvf,
  output logic [DEC_W+STEP_W-1:0] coefWord,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic                    inSol,
  input  logic [PIX_W-1:0]        inData,
  output logic                    outValid,
  input  logic                    outReady,
  output logic                    outSol,
  output logic [PIX_W-1:0]        outData
);
  rszStrobe_t        strb;
  logic [DEC_W-1:0]  decim;
  logic [STEP_W-1:0] step;
  logic [ADDR_W:0]   wSize;

  resz_ctrl #(
    .IN_MAX(IN_MAX), .OUT_MAX(OUT_MAX), .DEC_MAX(DEC_MAX),
    .FRAC_W(FRAC_W), .STEP_W(STEP_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart),
    .cfgInSize(cfgInSize), .cfgOutSize(cfgOutSize),
    .inValid(inValid), .inSol(inSol), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .outSol(outSol),
    .cfgBusy(cfgBusy), .cfgErr(cfgErr), .cfgOvf(cfgOvf),
    .decim(decim), .step(step), .wSize(wSize), .strb(strb)
  );

  resz_dp #(
    .PIX_W(PIX_W), .OUT_MAX(OUT_MAX), .DEC_MAX(DEC_MAX),
    .FRAC_W(FRAC_W), .STEP_W(STEP_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .decim(decim), .step(step), .wSize(wSize), .outData(outData)
  );

  assign coefWord = {decim, step};
endmodule

// File: rtl/resz_chk.sv
module resz_chk #(
  parameter int PIX_W   = 8,
  parameter int DEC_MAX = 2,
  parameter int STEP_W  = 14,
  parameter int BUSY_MAX = 16,
  localparam int DEC_W  = $clog2(DEC_MAX + 1)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    cfgBusy,
  input logic                    cfgErr,
  input logic                    cfgOvf,
  input logic [DEC_W+STEP_W-1:0] coefWord,
  input logic                    inReady,
  input logic                    outValid,
  input logic                    outReady,
  input logic                    outSol,
  input logic [PIX_W-1:0]        outData
);
  logic [5:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (!cfgBusy) busyCnt <= '0;
    else if (busyCnt != '1) busyCnt <= busyCnt + 1'b1;
  end

  p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgBusy |-> busyCnt < 6'(BUSY_MAX));

  p_err_stall_r1: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (!inReady && !outValid));

  p_dec_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    coefWord[DEC_W+STEP_W-1:STEP_W] <= DEC_W'(DEC_MAX));

  p_clamp_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgOvf |-> coefWord[STEP_W-1:0] == {STEP_W{1'b1}});

  p_in_out_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outSol)));
endmodule

bind line_resizer resz_chk #(
  .PIX_W(PIX_W), .DEC_MAX(DEC_MAX), .STEP_W(STEP_W)
) i_resz_chk (
  .clk(clk), .rstN(rstN), .cfgBusy(cfgBusy), .cfgErr(cfgErr),
  .cfgOvf(cfgOvf), .coefWord(coefWord), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outSol(outSol),
  .outData(outData)
);

// File: tb/test_line_resizer.sv
module test_line_resizer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgStart = 1'b0;
  logic [12:0] cfgInSize = '0;
  logic [10:0] cfgOutSize = '0;
  logic        cfgBusy, cfgErr, cfgOvf;
  logic [15:0] coefWord;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        inSol = 1'b0;
  logic [7:0]  inData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        outSol;
  logic [7:0]  outData;

  int nTests = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  line_resizer i_line_resizer (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgInSize(cfgInSize),
    .cfgOutSize(cfgOutSize), .cfgBusy(cfgBusy), .cfgErr(cfgErr),
    .cfgOvf(cfgOvf), .coefWord(coefWord), .inValid(inValid),
    .inReady(inReady), .inSol(inSol), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outSol(outSol),
    .outData(outData)
  );

  int mErr, mDec, mStep, mOvf, mW;
  int pix [64];
  int expo [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelCoef(input int inS, input int outS);
    int q;
    mErr = (inS > 4096 || inS < 1 || outS > 1024 || outS < 2 || outS * 4 < inS) ? 1 : 0;
    mW = inS;
    mDec = 0;
    while ((mW > 1024 || mW >= 2 * outS) && mDec < 2) begin
      mW = mW >> 1;
      mDec++;
    end
    q = (mErr != 0) ? 0 : (8192 * (mW - 1)) / (outS - 1);
    mOvf = (q >= 16384) ? 1 : 0;
    mStep = (mOvf != 0) ? 16383 : q;
  endtask

  task automatic modelLine(input int inS, input int outS, input int seed);
    int wk [64];
    int len;
    for (int i = 0; i < 64; i++) wk[i] = 0;
    for (int i = 0; i < inS; i++) begin
      pix[i] = (i * 53 + seed * 29 + 7) % 256;
      wk[i] = pix[i];
    end
    modelCoef(inS, outS);
    len = inS;
    for (int s = 0; s < mDec; s++) begin
      for (int i = 0; i < len / 2; i++) wk[i] = (wk[2*i] + wk[2*i+1] + 1) >> 1;
      len = len / 2;
    end
    for (int j = 0; j < outS; j++) begin
      int pos, idx, f, li, ri;
      pos = j * mStep;
      idx = pos >> 13;
      f = (pos >> 5) & 255;
      li = (idx > len - 1) ? len - 1 : idx;
      ri = (idx + 1 > len - 1) ? len - 1 : idx + 1;
      expo[j] = (wk[li] * (256 - f) + wk[ri] * f + 128) >> 8;
    end
  endtask

  task automatic doCfg(input int inS, input int outS);
    int cyc;
    @(negedge clk);
    cfgInSize = 13'(inS);
    cfgOutSize = 11'(outS);
    cfgStart = 1'b1;
    @(negedge clk);
    cfgStart = 1'b0;
    cyc = 0;
    while (cfgBusy && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc <= 16, "R6 busy cycles", cyc, 16);
  endtask

  task automatic cfgCheck(input int inS, input int outS, input string req);
    doCfg(inS, outS);
    modelCoef(inS, outS);
    chk(cfgErr == mErr[0], {req, " error flag"}, int'(cfgErr), mErr);
    if (mErr != 0) begin
      chk(!inReady, "R1 no input after error", int'(inReady), 0);
      chk(coefWord == 16'h0, "R1 coefficient cleared", int'(coefWord), 0);
    end else begin
      chk(coefWord[15:14] == 2'(mDec), "R3 halving count", int'(coefWord[15:14]), mDec);
      chk(coefWord[13:0] == 14'(mStep), {req, " step"}, int'(coefWord[13:0]), mStep);
      chk(cfgOvf == mOvf[0], "R5 overflow flag", int'(cfgOvf), mOvf);
    end
  endtask

  task automatic sendPix(input int v, input bit sol);
    @(negedge clk);
    inValid = 1'b1;
    inSol = sol;
    inData = 8'(v);
    while (!inReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic runLine(input int inS, input int outS, input int seed,
                         input bit backp, input bit preamble, input string req);
    int j, cyc, stallVal, stallSol;
    bit stalled;
    modelLine(inS, outS, seed);
    if (preamble) begin
      sendPix(8'hEE, 1'b0);
      sendPix(8'h11, 1'b0);
    end
    for (int i = 0; i < inS; i++) sendPix(pix[i], i == 0);
    @(negedge clk);
    inValid = 1'b0;
    inSol = 1'b0;
    chk(!inReady, "R10 input blocked while emitting", int'(inReady), 0);
    j = 0;
    cyc = 0;
    stalled = 1'b0;
    stallVal = 0;
    stallSol = 0;
    while (j < outS && cyc < 2000) begin
      outReady = backp ? (cyc % 3 != 0) : 1'b1;
      if (outValid) begin
        if (stalled) begin
          chk(int'(outData) == stallVal && int'(outSol) == stallSol,
              "R11 stalled output held", int'(outData), stallVal);
        end
        if (outReady) begin
          chk(int'(outData) == expo[j], req, int'(outData), expo[j]);
          chk(outSol == (j == 0), "R9 start-of-line marker", int'(outSol), int'(j == 0));
          j++;
          stalled = 1'b0;
        end else begin
          stalled = 1'b1;
          stallVal = int'(outData);
          stallSol = int'(outSol);
        end
      end
      @(negedge clk);
      cyc++;
    end
    outReady = 1'b0;
    chk(j == outS, "R9 output count", j, outS);
    chk(!outValid && inReady, "R9 no extra output", int'(outValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  task automatic testReset();
    @(negedge clk);
    chk(!inReady && !outValid, "R12 stream idle", int'(inReady), 0);
    chk(!cfgBusy && !cfgErr && !cfgOvf, "R12 flags clear", int'(cfgBusy), 0);
  endtask

  task automatic testClamp();
    cfgCheck(5, 3, "R5 clamped step");
    runLine(5, 3, 1, 1'b0, 1'b0, "R8 clamped line");
  endtask

  task automatic testDecim();
    cfgCheck(16, 4, "R3 two halvings");
    runLine(16, 4, 2, 1'b0, 1'b0, "R7 double halving");
    cfgCheck(9, 4, "R7 odd input");
    runLine(9, 4, 3, 1'b0, 1'b0, "R7 trailing pixel dropped");
  endtask

  task automatic testInterp();
    cfgCheck(10, 6, "R4 fractional step");
    runLine(10, 6, 4, 1'b1, 1'b0, "R8 downscale blend");
    cfgCheck(3, 5, "R4 upscale step");
    runLine(3, 5, 5, 1'b1, 1'b0, "R8 upscale blend");
  endtask

  task automatic testLines();
    cfgCheck(8, 8, "R4 unity step");
    runLine(8, 8, 6, 1'b0, 1'b1, "R10 preamble discarded");
    runLine(8, 8, 7, 1'b0, 1'b0, "R9 second line");
  endtask

  task automatic testLimits();
    cfgCheck(4097, 1024, "R1 input too long");
    cfgCheck(20, 1025, "R1 output too long");
    cfgCheck(10, 1, "R1 output of one");
    cfgCheck(0, 4, "R1 empty input");
    cfgCheck(41, 10, "R2 beyond four to one");
    cfgCheck(40, 10, "R2 exactly four to one");
    cfgCheck(4096, 1024, "R3 largest input");
    cfgCheck(2048, 1024, "R3 halving above limit");
    cfgCheck(1500, 1024, "R4 long line step");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testClamp();
    testDecim();
    testInterp();
    testLines();
    testLimits();
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule